// File: doc/BRIEF.md
# Branch and Jump Target Unit

This unit resolves control transfers for a core whose integer registers are 128 bits wide and are carried as a low and a high 64-bit half. For one accepted operation it evaluates a conditional branch, an unconditional PC-relative jump or a register-indirect jump. It produces the taken decision, the next fetch address, the return address and its write enable, and an instruction-address-misaligned flag. Each operation presented with `in_valid` is resolved combinationally and captured in one output register stage, so results appear one clock later and hold until the next accepted operation.

The wide magnitude compare never uses a 128-bit adder. The low halves produce a borrow, and that borrow enters a single-width subtraction of the high halves. The signed result is the high difference's sign corrected for overflow. A decoder hint that the second source is the hard-wired zero register skips the second operand altogether. The alignment rule for targets follows an input that says whether 16-bit instructions are enabled.

Top module: `bjt_unit`

## Requirements
- R1: Condition code 0 (equal) is met when both halves of the two operands match, and code 1 (not equal) is met otherwise. A difference confined to the high half must be detected.
- R2: Condition code 4 (signed less) and code 5 (signed greater-or-equal) compare the full 128-bit two's-complement values, including operands whose high-half difference overflows.
- R3: Condition code 6 (unsigned less) and code 7 (unsigned greater-or-equal) compare the full 128-bit unsigned values, with a borrow from the low halves carried into the high-half compare. Code 7 is the inverse of code 6.
- R4: When `rs2_zero` is 1, the `src2_lo`/`src2_hi` values are ignored and the first operand is compared against zero.
- R5: For a branch (`xfer_kind` 0) the target is `pc + imm`. A branch that is not taken sets `next_pc` to the following-instruction address and never flags a misalignment.
- R6: A relative jump (`xfer_kind` 1) is always taken, with `next_pc = pc + imm`.
- R7: An indirect jump (`xfer_kind` 2) is always taken, with target `src1_lo + imm` and bit 0 of the target cleared.
- R8: With `rvc_en` 0, a taken branch or relative jump whose target has bit 1 or bit 0 set raises `misalign_exc`, and an indirect jump whose target has bit 1 set also raises it. With `rvc_en` 1 it is never raised. On a raised flag `next_pc` carries the offending target and `link_wr` is 0.
- R9: `link_val` is `pc + 4`, or `pc + 2` when `short_insn` is 1. `link_wr` is 1 for a relative or indirect jump unless `rd_zero` is 1 or the misalignment flag is raised.
- R10: `xfer_kind` 3 and the unused condition codes 2 and 3 never take a transfer. The next PC is the following-instruction address.
- R11: Outputs register the operation accepted with `in_valid` one clock later, and `out_valid` pulses for that single cycle. Without `in_valid` all outputs other than `out_valid` keep their values.
- R12: During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| xfer_kind | input | 2 | 0 branch, 1 relative jump, 2 indirect jump, 3 no transfer |
| cond_code | input | 3 | Branch condition (0,1,4,5,6,7 as in R1 to R3) |
| pc | input | 64 | Address of the current instruction |
| imm | input | 64 | Sign-extended offset |
| src1_lo | input | 64 | First operand, low half (also indirect jump base) |
| src1_hi | input | 64 | First operand, high half |
| src2_lo | input | 64 | Second operand, low half |
| src2_hi | input | 64 | Second operand, high half |
| rs2_zero | input | 1 | Second source is the zero register |
| rvc_en | input | 1 | 16-bit instructions enabled (relaxed alignment) |
| short_insn | input | 1 | Current instruction is a 16-bit encoding |
| rd_zero | input | 1 | Destination is the zero register |
| out_valid | output | 1 | Registered result valid |
| taken | output | 1 | Transfer taken |
| next_pc | output | 64 | Next fetch address or offending target |
| link_wr | output | 1 | Write return address to destination |
| link_val | output | 64 | Address of the following instruction |
| misalign_exc | output | 1 | Instruction-address-misaligned exception |

## Verification
The hardest case to reach is a wide compare whose verdict depends on the borrow chain or on signed overflow in the high half. Random operands almost never make the low halves decide a compare of equal high halves, and they rarely give the most negative high half against a positive one. The stimulus table places operands on exactly these edges and adds pairs that differ only in the high half. It also uses garbage second operands under the zero-register hint, so a compare that wrongly reads them changes the verdict. Misaligned targets are produced through both the immediate and the base register, each with 16-bit support off and then on.

// File: rtl/bjt_pkg.sv
package bjt_pkg;

  typedef enum logic [1:0] {
    XK_BRANCH = 2'd0,
    XK_JAL    = 2'd1,
    XK_JALR   = 2'd2,
    XK_NONE   = 2'd3
  } xfer_kind_e;

  typedef enum logic [2:0] {
    CC_EQ  = 3'd0,
    CC_NE  = 3'd1,
    CC_LT  = 3'd4,
    CC_GE  = 3'd5,
    CC_LTU = 3'd6,
    CC_GEU = 3'd7
  } cond_e;

endpackage

// File: rtl/bjt_cmp_wide.sv
// Multi-word compare built from word-wide borrow steps.
module bjt_cmp_wide #(
  parameter int W     = 64,
  parameter int WORDS = 2
) (
  input  logic [WORDS*W-1:0] a,
  input  logic [WORDS*W-1:0] b,
  input  logic               b_zero,
  output logic               eq,
  output logic               lt,
  output logic               ltu
);
  localparam int TOT = WORDS * W;

  logic [WORDS:0]   brw;
  logic [WORDS-1:0] neq;
  logic             top_sign;

  assign brw[0] = 1'b0;

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [W-1:0] aw;
    logic [W-1:0] bw;
    assign aw = a[g*W +: W];
    assign bw = b[g*W +: W];

    if (g == WORDS - 1) begin : g_top
      logic [W:0] sub;
      assign sub      = {1'b0, aw} - {1'b0, bw} - {{W{1'b0}}, brw[g]};
      assign brw[g+1] = sub[W];
      assign top_sign = sub[W-1];
      // lower words equal means no borrow in, so zero difference means equal
      assign neq[g]   = |sub[W-1:0];
    end else begin : g_low
      assign brw[g+1] = (aw < bw) | ((aw == bw) & brw[g]);
      assign neq[g]   = |(aw ^ bw);
    end
  end

  logic a_sign;
  logic b_sign;
  logic eq_full;
  logic lt_full;

  assign a_sign  = a[TOT-1];
  assign b_sign  = b[TOT-1];
  assign eq_full = ~|neq;
  assign lt_full = top_sign ^ ((top_sign ^ a_sign) & (a_sign ^ b_sign));

  always_comb begin
    if (b_zero) begin
      eq  = ~|a;
      lt  = a_sign;
      ltu = 1'b0;
    end else begin
      eq  = eq_full;
      lt  = lt_full;
      ltu = brw[WORDS];
    end
  end

endmodule

// File: rtl/bjt_target.sv
// Target address, following-instruction address and alignment check.
module bjt_target #(
  parameter int XLEN     = 64,
  parameter int LONG_LEN = 4,
  parameter int SHORT_LEN = 2
) (
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] imm,
  input  logic [XLEN-1:0] base,
  input  logic            indirect,
  input  logic            short_insn,
  input  logic            rvc_en,
  output logic [XLEN-1:0] succ,
  output logic [XLEN-1:0] tgt,
  output logic            misalign
);
  localparam logic [XLEN-1:0] STEP_L = XLEN'(LONG_LEN);
  localparam logic [XLEN-1:0] STEP_S = XLEN'(SHORT_LEN);

  logic [XLEN-1:0] add_a;
  logic [XLEN-1:0] sum;

  assign succ  = pc + (short_insn ? STEP_S : STEP_L);
  assign add_a = indirect ? base : pc;
  assign sum   = add_a + imm;

  always_comb begin
    if (indirect) begin
      tgt      = {sum[XLEN-1:1], 1'b0};
      misalign = ~rvc_en & sum[1];
    end else begin
      tgt      = sum;
      misalign = ~rvc_en & (|sum[1:0]);
    end
  end

endmodule

// File: rtl/bjt_unit.sv
module bjt_unit #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [1:0]      xfer_kind,
  input  logic [2:0]      cond_code,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] imm,
  input  logic [XLEN-1:0] src1_lo,
  input  logic [XLEN-1:0] src1_hi,
  input  logic [XLEN-1:0] src2_lo,
  input  logic [XLEN-1:0] src2_hi,
  input  logic            rs2_zero,
  input  logic            rvc_en,
  input  logic            short_insn,
  input  logic            rd_zero,
  output logic            out_valid,
  output logic            taken,
  output logic [XLEN-1:0] next_pc,
  output logic            link_wr,
  output logic [XLEN-1:0] link_val,
  output logic            misalign_exc
);
  import bjt_pkg::*;

  localparam int WORDS = 2;

  // reset: asynchronous assertion, synchronous release
  logic rst_meta_n;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  xfer_kind_e kind;
  assign kind = xfer_kind_e'(xfer_kind);

  logic cmp_eq;
  logic cmp_lt;
  logic cmp_ltu;

  bjt_cmp_wide #(.W(XLEN), .WORDS(WORDS)) u_cmp (
    .a      ({src1_hi, src1_lo}),
    .b      ({src2_hi, src2_lo}),
    .b_zero (rs2_zero),
    .eq     (cmp_eq),
    .lt     (cmp_lt),
    .ltu    (cmp_ltu)
  );

  logic [XLEN-1:0] succ;
  logic [XLEN-1:0] tgt;
  logic            tgt_bad;

  bjt_target #(.XLEN(XLEN)) u_tgt (
    .pc         (pc),
    .imm        (imm),
    .base       (src1_lo),
    .indirect   (kind == XK_JALR),
    .short_insn (short_insn),
    .rvc_en     (rvc_en),
    .succ       (succ),
    .tgt        (tgt),
    .misalign   (tgt_bad)
  );

  // next-state
  logic            cond_met;
  logic            taken_d;
  logic            exc_d;
  logic            lwr_d;
  logic [XLEN-1:0] next_d;

  always_comb begin
    case (cond_e'(cond_code))
      CC_EQ:   cond_met = cmp_eq;
      CC_NE:   cond_met = ~cmp_eq;
      CC_LT:   cond_met = cmp_lt;
      CC_GE:   cond_met = ~cmp_lt;
      CC_LTU:  cond_met = cmp_ltu;
      CC_GEU:  cond_met = ~cmp_ltu;
      default: cond_met = 1'b0;
    endcase
  end

  always_comb begin
    case (kind)
      XK_BRANCH: taken_d = cond_met;
      XK_JAL:    taken_d = 1'b1;
      XK_JALR:   taken_d = 1'b1;
      default:   taken_d = 1'b0;
    endcase
    exc_d  = taken_d & tgt_bad;
    next_d = taken_d ? tgt : succ;
    lwr_d  = ((kind == XK_JAL) || (kind == XK_JALR)) & ~rd_zero & ~exc_d;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid    <= 1'b0;
      taken        <= 1'b0;
      next_pc      <= '0;
      link_wr      <= 1'b0;
      link_val     <= '0;
      misalign_exc <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        taken        <= taken_d;
        next_pc      <= next_d;
        link_wr      <= lwr_d;
        link_val     <= succ;
        misalign_exc <= exc_d;
      end
    end
  end

endmodule

// File: rtl/bjt_unit_chk.sv
module bjt_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [1:0]      xfer_kind,
  input logic            rvc_en,
  input logic            rd_zero,
  input logic            out_valid,
  input logic            taken,
  input logic [XLEN-1:0] next_pc,
  input logic            link_wr,
  input logic            misalign_exc
);

  // R11
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(next_pc) && $stable(taken)));

  // R8
  rvc_no_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rvc_en) |=> !misalign_exc);

  // R8
  exc_no_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_exc |-> !link_wr);

  // R5
  exc_needs_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_exc |-> taken);

  // R9
  rd0_no_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rd_zero) |=> !link_wr);

  // R7
  jalr_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && xfer_kind == 2'd2) |=> (taken && !next_pc[0]));

  // R10
  none_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && xfer_kind == 2'd3) |=> (!taken && !link_wr && !misalign_exc));

endmodule

bind bjt_unit bjt_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .in_valid     (in_valid),
  .xfer_kind    (xfer_kind),
  .rvc_en       (rvc_en),
  .rd_zero      (rd_zero),
  .out_valid    (out_valid),
  .taken        (taken),
  .next_pc      (next_pc),
  .link_wr      (link_wr),
  .misalign_exc (misalign_exc)
);

// File: tb/tb_bjt_unit.sv
`timescale 1ns/1ps
module tb_bjt_unit;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  xfer_kind;
  logic [2:0]  cond_code;
  logic [63:0] pc, imm, src1_lo, src1_hi, src2_lo, src2_hi;
  logic        rs2_zero, rvc_en, short_insn, rd_zero;
  logic        out_valid, taken, link_wr, misalign_exc;
  logic [63:0] next_pc, link_val;

  bjt_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .xfer_kind(xfer_kind),
    .cond_code(cond_code), .pc(pc), .imm(imm), .src1_lo(src1_lo),
    .src1_hi(src1_hi), .src2_lo(src2_lo), .src2_hi(src2_hi),
    .rs2_zero(rs2_zero), .rvc_en(rvc_en), .short_insn(short_insn),
    .rd_zero(rd_zero), .out_valid(out_valid), .taken(taken),
    .next_pc(next_pc), .link_wr(link_wr), .link_val(link_val),
    .misalign_exc(misalign_exc)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [1:0]  kind;
    logic [2:0]  cc;
    logic        rz, rvc, sh, rdz;
    logic [63:0] vpc, vimm, alo, ahi, blo, bhi;
    logic        e_tk, e_exc, e_lwr;
    logic [63:0] e_next, e_link;
    logic [7:0]  req;
  } vec_t;

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] SMIN = 64'h8000_0000_0000_0000;
  localparam logic [63:0] SMAX = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] P0   = 64'h1000;
  localparam int NV = 24;

  localparam vec_t VECS [NV] = '{
    // R1 equal
    '{2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, P0, 64'h40, 64'd5, 64'd7, 64'd5, 64'd7, 1'b1, 1'b0, 1'b0, 64'h1040, 64'h1004, 8'd1},
    // R1 high half differs, EQ
    '{2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, P0, 64'h40, 64'd5, 64'd7, 64'd5, 64'd8, 1'b0, 1'b0, 1'b0, 64'h1004, 64'h1004, 8'd1},
    // R1 high half differs, NE
    '{2'd0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, P0, 64'h40, 64'd5, 64'd7, 64'd5, 64'd8, 1'b1, 1'b0, 1'b0, 64'h1040, 64'h1004, 8'd1},
    // R2 negative < positive
    '{2'd0, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, P0, 64'h40, 64'd0, ONES, 64'd0, 64'd1, 1'b1, 1'b0, 1'b0, 64'h1040, 64'h1004, 8'd2},
    // R2 most negative GE positive: overflow case, not taken
    '{2'd0, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0, P0, 64'h40, 64'd0, SMIN, 64'd0, 64'd1, 1'b0, 1'b0, 1'b0, 64'h1004, 64'h1004, 8'd2},
    // R2 equal highs, low decides
    '{2'd0, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, P0, 64'h40, 64'd1, 64'd0, 64'd2, 64'd0, 1'b1, 1'b0, 1'b0, 64'h1040, 64'h1004, 8'd2},
    // R3 unsigned less via high half
    '{2'd0, 3'd6, 1'b0, 1'b0, 1'b0, 1'b0, P0, 64'h40, ONES, 64'd0, 64'd0, 64'd1, 1'b1, 1'b0, 1'b0, 64'h1040, 64'h1004, 8'd3},
    // R3 GEU
    '{2'd0, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, P0, 64'h40, 64'd0, 64'd1, ONES, 64'd0, 1'b1, 1'b0, 1'b0, 64'h1040, 64'h1004, 8'd3},
    // R3 large high half, not less
    '{2'd0, 3'd6, 1'b0, 1'b0, 1'b0, 1'b0, P0, 64'h40, 64'd0, ONES, 64'd0, 64'd1, 1'b0, 1'b0, 1'b0, 64'h1004, 64'h1004, 8'd3},
    // R4 zero source, garbage in src2, EQ vs zero
    '{2'd0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, P0, 64'h40, 64'd0, 64'd0, 64'hDEAD, 64'hBEEF, 1'b1, 1'b0, 1'b0, 64'h1040, 64'h1004, 8'd4},
    // R4 zero source, LT vs zero on positive
    '{2'd0, 3'd4, 1'b1, 1'b0, 1'b0, 1'b0, P0, 64'h40, 64'd5, 64'd1, 64'd0, SMAX, 1'b0, 1'b0, 1'b0, 64'h1004, 64'h1004, 8'd4},
    // R8 misaligned branch target
    '{2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, P0, 64'h42, 64'd5, 64'd7, 64'd5, 64'd7, 1'b1, 1'b1, 1'b0, 64'h1042, 64'h1004, 8'd8},
    // R8 same with 16-bit support
    '{2'd0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, P0, 64'h42, 64'd5, 64'd7, 64'd5, 64'd7, 1'b1, 1'b0, 1'b0, 64'h1042, 64'h1004, 8'd8},
    // R6 relative jump
    '{2'd1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, P0, 64'h200, 64'd0, 64'd0, 64'd0, 64'd0, 1'b1, 1'b0, 1'b1, 64'h1200, 64'h1004, 8'd6},
    // R7 indirect jump clears bit 0
    '{2'd2, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, P0, 64'h10, 64'h2001, 64'd9, 64'd0, 64'd0, 1'b1, 1'b0, 1'b1, 64'h2010, 64'h1004, 8'd7},
    // R8 indirect target bit 1 set
    '{2'd2, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, P0, 64'h1, 64'h2001, 64'd0, 64'd0, 64'd0, 1'b1, 1'b1, 1'b0, 64'h2002, 64'h1004, 8'd8},
    // R8 same with 16-bit support
    '{2'd2, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, P0, 64'h1, 64'h2001, 64'd0, 64'd0, 64'd0, 1'b1, 1'b0, 1'b1, 64'h2002, 64'h1004, 8'd8},
    // R9 short encoding, rd zero
    '{2'd1, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, P0, 64'h200, 64'd0, 64'd0, 64'd0, 64'd0, 1'b1, 1'b0, 1'b0, 64'h1200, 64'h1002, 8'd9},
    // R10 no-transfer kind
    '{2'd3, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, P0, 64'h200, 64'd5, 64'd7, 64'd5, 64'd7, 1'b0, 1'b0, 1'b0, 64'h1004, 64'h1004, 8'd10},
    // R8 relative jump misaligned
    '{2'd1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, P0, 64'h202, 64'd0, 64'd0, 64'd0, 64'd0, 1'b1, 1'b1, 1'b0, 64'h1202, 64'h1004, 8'd8},
    // R5 backward branch
    '{2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, P0, 64'hFFFF_FFFF_FFFF_FF00, 64'd5, 64'd7, 64'd5, 64'd7, 1'b1, 1'b0, 1'b0, 64'h0F00, 64'h1004, 8'd5},
    // R10 unused condition code 2
    '{2'd0, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, P0, 64'h40, 64'd5, 64'd7, 64'd5, 64'd7, 1'b0, 1'b0, 1'b0, 64'h1004, 64'h1004, 8'd10},
    // R5 short not-taken, misaligned target ignored
    '{2'd0, 3'd1, 1'b0, 1'b0, 1'b1, 1'b0, P0, 64'h43, 64'd5, 64'd7, 64'd5, 64'd7, 1'b0, 1'b0, 1'b0, 64'h1002, 64'h1002, 8'd5},
    // R3 low borrow into equal highs
    '{2'd0, 3'd6, 1'b0, 1'b0, 1'b0, 1'b0, P0, 64'h40, 64'd0, 64'd5, 64'd1, 64'd5, 1'b1, 1'b0, 1'b0, 64'h1040, 64'h1004, 8'd3}
  };

  int  n_run;
  int  n_fail;
  bit  done;

  task automatic chk(input string what, input int req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    xfer_kind  = v.kind;  cond_code = v.cc;   rs2_zero = v.rz;
    rvc_en     = v.rvc;   short_insn = v.sh;  rd_zero  = v.rdz;
    pc         = v.vpc;   imm = v.vimm;
    src1_lo    = v.alo;   src1_hi = v.ahi;
    src2_lo    = v.blo;   src2_hi = v.bhi;
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; in_valid = 1'b0;
    drive(VECS[0]);
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("reset out_valid", 12, 64'(out_valid), 64'd0);
    chk("reset next_pc", 12, next_pc, 64'd0);
    chk("reset link", 12, {link_val[62:0], link_wr}, 64'd0);
    chk("reset flags", 12, {62'd0, taken, misalign_exc}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("out_valid", 11, 64'(out_valid), 64'd1);
      chk("taken", int'(VECS[i].req), 64'(taken), 64'(VECS[i].e_tk));
      chk("next_pc", int'(VECS[i].req), next_pc, VECS[i].e_next);
      chk("misalign_exc", int'(VECS[i].req), 64'(misalign_exc), 64'(VECS[i].e_exc));
      chk("link_wr", int'(VECS[i].req), 64'(link_wr), 64'(VECS[i].e_lwr));
      chk("link_val", int'(VECS[i].req), link_val, VECS[i].e_link);
    end

    // R11: idle inputs change, outputs hold (last vector left next_pc 0x1040)
    drive(VECS[13]);
    @(negedge clk);
    chk("hold out_valid", 11, 64'(out_valid), 64'd0);
    chk("hold next_pc", 11, next_pc, 64'h1040);
    chk("hold link_wr", 11, 64'(link_wr), 64'd0);

    // R4: zero-source hint ignores src2 even when it would flip the verdict
    drive(VECS[0]);
    rs2_zero = 1'b1; src1_lo = 64'd3; src1_hi = 64'd0;
    src2_lo = 64'd3; src2_hi = 64'd0;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("zero hint EQ ignores src2", 4, 64'(taken), 64'd0);

    // R12: reset in the middle clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    chk("mid reset next_pc", 12, next_pc, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule